// File: doc/BRIEF.md
# LPC Cycle Capture Filter

This block sits on a Low Pin Count bus as a target. It watches the framing strobe (active low) and the 4-bit LAD nibble on every clock and tracks the phase of each transaction. It completes only I/O cycles and TPM-style cycles. A TPM-style cycle has its own start nibble but the same phase sequence as an I/O cycle. For those cycles it answers with a SYNC and a turnaround on its own LAD output, and it returns read data from a side input. At the end of each such cycle it publishes one 32-bit record holding the address, the direction and the data, together with a single-clock ready strobe.

Any other cycle type is still followed clock by clock, so the block keeps its place in the framing. A flag raised at the cycle-type nibble keeps the LAD driver and the record strobe off until the block is back at idle. Pulling the frame strobe low in the middle of a transaction abandons that transaction. If the nibble seen in the same clock is a start code, a new transaction begins.

Top module: `lpc_capture_filter`

## Requirements
- R1: While `rst` is high and in the first clock after it, `lad_oe_o` and `ready_o` are low and `word_o` is zero.
- R2: A transaction begins only in a clock where `lframe_n_i` is low and `lad_i` is 4'h0 (I/O) or 4'h5 (TPM). The block stays in the start phase while that holds. A low frame with any other nibble returns it to waiting, so the nibbles that follow cause no drive and no strobe.
- R3: In the first clock with `lframe_n_i` high after a start, nibble 4'h0 selects a read and 4'h2 selects a write. The next four nibbles form the 16-bit address, most significant nibble first.
- R4: A write carries two data nibbles, low nibble first, then two host turnaround clocks. The block then drives SYNC 4'h0 for one clock and 4'hF for one clock, and releases LAD in the clock after.
- R5: For a read, `rd_data_i` is sampled at the clock edge that ends the last address nibble. After two host turnaround clocks the block drives SYNC 4'h0, then the low and the high data nibble, then 4'hF, and releases LAD in the next clock.
- R6: In the clock after the final turnaround clock of a completed I/O or TPM cycle, `ready_o` is high for exactly one clock. `word_o` then holds the address in [31:16], the direction in bit 15 (1 = write) and the data in [7:0], with zeros in [14:8]. `word_o` does not change at any other time.
- R7: Any other cycle-type nibble (for example 4'h4, 4'h6 or 4'h8) marks the transaction as skipped. `lad_oe_o` then stays low in every clock of that transaction, no ready strobe appears and `word_o` keeps its value.
- R8: The skip mark is cleared on return to idle, so a supported cycle that starts right after a skipped one is answered and recorded normally.
- R9: A low `lframe_n_i` after the cycle-type clock abandons the transaction, with no strobe and no record. If the nibble in that clock is a start code, it begins a new transaction.
- R10: `lad_oe_o` is low in every clock in which `lframe_n_i` is low, even in a phase where the block would otherwise drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| lframe_n_i | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | LAD nibble as seen on the bus |
| rd_data_i | input | 8 | Byte to return for read cycles |
| lad_o | output | 4 | Nibble the block drives onto LAD |
| lad_oe_o | output | 1 | LAD output enable |
| word_o | output | 32 | Last recorded transaction: address, direction, data |
| ready_o | output | 1 | One-clock strobe when word_o is updated |

## Verification
The bench sends memory and DMA cycle types, both back to back with supported cycles and alone. A filter that only decoded the direction bit would then drive SYNC and strobe a record, and a skip mark that never cleared would silence the I/O read that follows. It abandons cycles mid-transfer, including one cut at the SYNC clock: a design missing the frame gating would show its enable in that clock, and one that recorded on partial data would pulse ready. It changes the read byte right after the address completes, so sampling too late returns the wrong byte, and it holds the start nibble over several clocks and uses the TPM start code, which a strict single-clock start check would miss.

// File: rtl/lpcf_pkg.sv
package lpcf_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_ADDR,
    PH_WDATA,
    PH_HTAR,
    PH_SYNC,
    PH_RDATA,
    PH_PTAR
  } phase_e;

  localparam logic [3:0] NIB_START_IO  = 4'h0;
  localparam logic [3:0] NIB_START_TPM = 4'h5;
  localparam logic [3:0] NIB_CYC_RD    = 4'h0;
  localparam logic [3:0] NIB_CYC_WR    = 4'h2;
  localparam logic [3:0] NIB_SYNC_OK   = 4'h0;
  localparam logic [3:0] NIB_PARK      = 4'hF;

endpackage

// File: rtl/lpcf_frame_fsm.sv
module lpcf_frame_fsm
  import lpcf_pkg::*;
#(
  parameter int ADDR_NIB = 4,
  parameter int DATA_NIB = 2,
  parameter int TAR_CLKS = 2,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lframe_n_i,
  input  logic [3:0]       lad_i,
  output phase_e           phase_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             write_q,
  output logic             skip_q,
  output phase_e           nxt_phase,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             nxt_skip,
  output logic             done_o,
  output logic             addr_done_o
);

  localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_NIB - 1);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_NIB - 1);
  localparam logic [IDX_W-1:0] TAR_LAST  = IDX_W'(TAR_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);

  logic is_start;
  logic nxt_write;

  assign is_start = !lframe_n_i && (lad_i == NIB_START_IO || lad_i == NIB_START_TPM);

  always_comb begin
    nxt_phase = phase_q;
    nxt_idx   = idx_q;
    nxt_write = write_q;
    nxt_skip  = skip_q;
    if (phase_q != PH_IDLE && phase_q != PH_START && !lframe_n_i) begin
      // mid-transaction frame: abandon, maybe restart
      nxt_phase = is_start ? PH_START : PH_IDLE;
      nxt_idx   = '0;
      nxt_skip  = 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          nxt_skip = 1'b0;
          if (is_start) nxt_phase = PH_START;
        end
        PH_START: begin
          if (!lframe_n_i) begin
            nxt_phase = is_start ? PH_START : PH_IDLE;
          end else begin
            nxt_phase = PH_ADDR;
            nxt_idx   = '0;
            nxt_write = lad_i[1];
            nxt_skip  = !(lad_i == NIB_CYC_RD || lad_i == NIB_CYC_WR);
          end
        end
        PH_ADDR: begin
          if (idx_q == ADDR_LAST) begin
            nxt_phase = write_q ? PH_WDATA : PH_HTAR;
            nxt_idx   = '0;
          end else begin
            nxt_idx = idx_q + IDX_ONE;
          end
        end
        PH_WDATA: begin
          if (idx_q == DATA_LAST) begin
            nxt_phase = PH_HTAR;
            nxt_idx   = '0;
          end else begin
            nxt_idx = idx_q + IDX_ONE;
          end
        end
        PH_HTAR: begin
          if (idx_q == TAR_LAST) begin
            nxt_phase = PH_SYNC;
            nxt_idx   = '0;
          end else begin
            nxt_idx = idx_q + IDX_ONE;
          end
        end
        PH_SYNC: begin
          nxt_phase = write_q ? PH_PTAR : PH_RDATA;
          nxt_idx   = '0;
        end
        PH_RDATA: begin
          if (idx_q == DATA_LAST) begin
            nxt_phase = PH_PTAR;
            nxt_idx   = '0;
          end else begin
            nxt_idx = idx_q + IDX_ONE;
          end
        end
        PH_PTAR: begin
          if (idx_q == TAR_LAST) begin
            nxt_phase = PH_IDLE;
            nxt_idx   = '0;
            nxt_skip  = 1'b0;
          end else begin
            nxt_idx = idx_q + IDX_ONE;
          end
        end
        default: begin
          nxt_phase = PH_IDLE;
          nxt_idx   = '0;
          nxt_skip  = 1'b0;
        end
      endcase
    end
  end

  assign done_o      = (phase_q == PH_PTAR) && (idx_q == TAR_LAST) && lframe_n_i && !skip_q;
  assign addr_done_o = (phase_q == PH_ADDR) && (idx_q == ADDR_LAST) && lframe_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      write_q <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      phase_q <= nxt_phase;
      idx_q   <= nxt_idx;
      write_q <= nxt_write;
      skip_q  <= nxt_skip;
    end
  end

  // R2: the start phase is only reached through a low frame
  a_r2_start_entry: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_START) |-> $past(!lframe_n_i));

  // R7: a skip mark only lives inside a transaction body
  a_r7_skip_phase: assert property (@(posedge clk) disable iff (rst)
    skip_q |-> (phase_q != PH_IDLE && phase_q != PH_START));

endmodule

// File: rtl/lpcf_capture.sv
module lpcf_capture
  import lpcf_pkg::*;
#(
  parameter int ADDR_NIB = 4,
  parameter int DATA_NIB = 2,
  parameter int WORD_W   = 32,
  parameter int IDX_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lframe_n_i,
  input  logic [3:0]         lad_i,
  input  phase_e             phase_q,
  input  logic [IDX_W-1:0]   idx_q,
  input  logic               write_q,
  input  logic               done_i,
  input  logic               addr_done_i,
  input  logic [4*DATA_NIB-1:0] rd_data_i,
  output logic [4*DATA_NIB-1:0] rd_hold_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               ready_o
);

  localparam int ADDR_W = 4 * ADDR_NIB;
  localparam int DATA_W = 4 * DATA_NIB;
  localparam int PAD_W  = WORD_W - ADDR_W - 1 - DATA_W;

  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_sh   <= '0;
      wdata     <= '0;
      rd_hold_o <= '0;
    end else begin
      if (phase_q == PH_ADDR && lframe_n_i)
        addr_sh <= {addr_sh[ADDR_W-5:0], lad_i};
      for (int k = 0; k < DATA_NIB; k++) begin
        if (phase_q == PH_WDATA && idx_q == IDX_W'(k) && lframe_n_i)
          wdata[4*k +: 4] <= lad_i;
      end
      if (addr_done_i)
        rd_hold_o <= rd_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      ready_o <= 1'b0;
    end else begin
      ready_o <= done_i;
      if (done_i)
        word_o <= {addr_sh, write_q, {PAD_W{1'b0}}, (write_q ? wdata : rd_hold_o)};
    end
  end

  // R6: the strobe is a single clock
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  // R6: a strobe follows the last turnaround clock
  a_r6_after_tar: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> $past(phase_q == PH_PTAR));

  // R6: the record holds between strobes
  a_r6_word_hold: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> $stable(word_o));

endmodule

// File: rtl/lpcf_lad_drive.sv
module lpcf_lad_drive
  import lpcf_pkg::*;
#(
  parameter int DATA_NIB = 2,
  parameter int IDX_W    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lframe_n_i,
  input  phase_e                nxt_phase,
  input  logic [IDX_W-1:0]      nxt_idx,
  input  logic                  nxt_skip,
  input  phase_e                phase_q,
  input  logic                  skip_q,
  input  logic [4*DATA_NIB-1:0] rd_hold_i,
  output logic [3:0]            lad_o,
  output logic                  lad_oe_o
);

  localparam int SLOTS = 2 ** IDX_W;

  logic [3:0] rd_nib [SLOTS];
  logic       drv_oe;
  logic [3:0] drv_val;
  logic       oe_q;
  logic [3:0] val_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_nib
    if (g < DATA_NIB) begin : g_used
      assign rd_nib[g] = rd_hold_i[4*g +: 4];
    end else begin : g_pad
      assign rd_nib[g] = 4'h0;
    end
  end

  always_comb begin
    drv_oe  = 1'b0;
    drv_val = NIB_PARK;
    case (nxt_phase)
      PH_SYNC: begin
        drv_oe  = 1'b1;
        drv_val = NIB_SYNC_OK;
      end
      PH_RDATA: begin
        drv_oe  = 1'b1;
        drv_val = rd_nib[nxt_idx];
      end
      PH_PTAR: begin
        drv_oe  = (nxt_idx == '0);
        drv_val = NIB_PARK;
      end
      default: begin
        drv_oe  = 1'b0;
        drv_val = NIB_PARK;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      val_q <= NIB_PARK;
    end else begin
      oe_q  <= drv_oe && !nxt_skip;
      val_q <= drv_val;
    end
  end

  assign lad_o    = val_q;
  assign lad_oe_o = oe_q && lframe_n_i;

  // R4: the driver is only armed in target-owned phases
  a_r4_oe_phase: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (phase_q == PH_SYNC || phase_q == PH_RDATA || phase_q == PH_PTAR));

  // R7: never drive inside a skipped transaction
  a_r7_no_drive_skip: assert property (@(posedge clk) disable iff (rst)
    skip_q |-> !lad_oe_o);

endmodule

// File: rtl/lpc_capture_filter.sv
module lpc_capture_filter
  import lpcf_pkg::*;
#(
  parameter int ADDR_NIB = 4,
  parameter int DATA_NIB = 2,
  parameter int TAR_CLKS = 2,
  parameter int WORD_W   = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lframe_n_i,
  input  logic [3:0]            lad_i,
  input  logic [4*DATA_NIB-1:0] rd_data_i,
  output logic [3:0]            lad_o,
  output logic                  lad_oe_o,
  output logic [WORD_W-1:0]     word_o,
  output logic                  ready_o
);

  localparam int MAX_A  = (ADDR_NIB > DATA_NIB) ? ADDR_NIB : DATA_NIB;
  localparam int MAX_N  = (MAX_A > TAR_CLKS) ? MAX_A : TAR_CLKS;
  localparam int IDX_W  = (MAX_N > 1) ? $clog2(MAX_N) : 1;
  localparam int DATA_W = 4 * DATA_NIB;

  phase_e             phase_q, nxt_phase;
  logic [IDX_W-1:0]   idx_q, nxt_idx;
  logic               write_q, skip_q, nxt_skip;
  logic               done, addr_done;
  logic [DATA_W-1:0]  rd_hold;

  lpcf_frame_fsm #(
    .ADDR_NIB(ADDR_NIB), .DATA_NIB(DATA_NIB), .TAR_CLKS(TAR_CLKS), .IDX_W(IDX_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .lframe_n_i(lframe_n_i), .lad_i(lad_i),
    .phase_q(phase_q), .idx_q(idx_q), .write_q(write_q), .skip_q(skip_q),
    .nxt_phase(nxt_phase), .nxt_idx(nxt_idx), .nxt_skip(nxt_skip),
    .done_o(done), .addr_done_o(addr_done)
  );

  lpcf_capture #(
    .ADDR_NIB(ADDR_NIB), .DATA_NIB(DATA_NIB), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) u_cap (
    .clk(clk), .rst(rst), .lframe_n_i(lframe_n_i), .lad_i(lad_i),
    .phase_q(phase_q), .idx_q(idx_q), .write_q(write_q),
    .done_i(done), .addr_done_i(addr_done), .rd_data_i(rd_data_i),
    .rd_hold_o(rd_hold), .word_o(word_o), .ready_o(ready_o)
  );

  lpcf_lad_drive #(
    .DATA_NIB(DATA_NIB), .IDX_W(IDX_W)
  ) u_drv (
    .clk(clk), .rst(rst), .lframe_n_i(lframe_n_i),
    .nxt_phase(nxt_phase), .nxt_idx(nxt_idx), .nxt_skip(nxt_skip),
    .phase_q(phase_q), .skip_q(skip_q), .rd_hold_i(rd_hold),
    .lad_o(lad_o), .lad_oe_o(lad_oe_o)
  );

endmodule

// File: tb/sim_lpc_capture_filter.sv
module sim_lpc_capture_filter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lframe_n = 1'b1;
  logic [3:0]  lad = 4'hF;
  logic [7:0]  rd_data = 8'h00;
  logic [3:0]  lad_o;
  logic        lad_oe;
  logic [31:0] word;
  logic        ready;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b0;
  bit finished = 1'b0;
  string cur_req = "R1";

  bit          exp_oe = 1'b0;
  logic [3:0]  exp_val = 4'h0;
  bit          exp_rdy = 1'b0;
  logic [31:0] exp_word = 32'h0;
  bit          pend_rdy = 1'b0;
  logic [31:0] pend_word = 32'h0;

  always #5 clk = ~clk;

  lpc_capture_filter u0 (
    .clk(clk), .rst(rst), .lframe_n_i(lframe_n), .lad_i(lad), .rd_data_i(rd_data),
    .lad_o(lad_o), .lad_oe_o(lad_oe), .word_o(word), .ready_o(ready)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the bench model
  always @(negedge clk) begin
    if (chk_en && !finished) begin
      chk("lad_oe", {31'b0, lad_oe}, {31'b0, exp_oe});
      if (exp_oe) chk("lad value", {28'b0, lad_o}, {28'b0, exp_val});
      chk("ready", {31'b0, ready}, {31'b0, exp_rdy});
      chk("word", word, exp_word);
    end
  end

  task automatic step(input bit lf, input logic [3:0] nib, input bit eoe, input logic [3:0] ev);
    @(posedge clk);
    #1;
    lframe_n = lf;
    lad      = nib;
    exp_oe   = eoe && lf;
    exp_val  = ev;
    exp_rdy  = pend_rdy;
    if (pend_rdy) exp_word = pend_word;
    pend_rdy = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 4'hF, 1'b0, 4'h0);
  endtask

  // one host transaction; len < 13 cuts it short
  task automatic xfer(input logic [3:0] st, input logic [3:0] cyc, input logic [15:0] a,
                      input logic [7:0] d, input logic [7:0] rdb, input int len,
                      input int extra_start);
    bit wr;
    bit ok;
    bit lfv [13];
    logic [3:0] nibv [13];
    bit oev [13];
    logic [3:0] valv [13];
    wr = cyc[1];
    ok = (cyc == 4'h0) || (cyc == 4'h2);
    rd_data = rdb;
    for (int i = 0; i < 13; i++) begin
      lfv[i] = 1'b1; nibv[i] = 4'hF; oev[i] = 1'b0; valv[i] = 4'h0;
    end
    lfv[0] = 1'b0; nibv[0] = st;
    nibv[1] = cyc;
    nibv[2] = a[15:12]; nibv[3] = a[11:8]; nibv[4] = a[7:4]; nibv[5] = a[3:0];
    if (wr) begin
      nibv[6] = d[3:0]; nibv[7] = d[7:4];
      oev[10] = ok; valv[10] = 4'h0;
      oev[11] = ok; valv[11] = 4'hF;
    end else begin
      oev[8]  = ok; valv[8]  = 4'h0;
      oev[9]  = ok; valv[9]  = rdb[3:0];
      oev[10] = ok; valv[10] = rdb[7:4];
      oev[11] = ok; valv[11] = 4'hF;
    end
    for (int e = 0; e < extra_start; e++) step(1'b0, st, 1'b0, 4'h0);
    for (int i = 0; i < len; i++) begin
      step(lfv[i], nibv[i], oev[i], valv[i]);
      if (i == 6) rd_data = ~rdb;
    end
    if (len == 13 && ok) begin
      pend_rdy  = 1'b1;
      pend_word = {a, wr, 7'b0, (wr ? d : rdb)};
    end
  endtask

  initial begin
    #1;
    repeat (2) @(posedge clk);
    chk_en = 1'b1;
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle(3);

    cur_req = "R4"; // write path, R3 decode
    xfer(4'h0, 4'h2, 16'h1234, 8'hA5, 8'h00, 13, 0);
    idle(2);
    cur_req = "R5"; // read path, sampling at address end
    xfer(4'h0, 4'h0, 16'hBEEF, 8'h00, 8'h3C, 13, 0);
    idle(2);
    cur_req = "R3";
    xfer(4'h0, 4'h2, 16'h8001, 8'h7E, 8'h00, 13, 0);
    xfer(4'h0, 4'h0, 16'h00F0, 8'h00, 8'hC9, 13, 0);
    idle(2);
    cur_req = "R2"; // TPM start code, stretched start
    xfer(4'h5, 4'h2, 16'h0F12, 8'h5A, 8'h00, 13, 2);
    xfer(4'h5, 4'h0, 16'h0F34, 8'h00, 8'h96, 13, 1);
    idle(2);
    cur_req = "R7"; // memory write, memory read, DMA
    xfer(4'h0, 4'h6, 16'h4444, 8'h11, 8'h22, 13, 0);
    idle(9);
    xfer(4'h0, 4'h4, 16'h5555, 8'h33, 8'h44, 13, 0);
    idle(9);
    xfer(4'h0, 4'h8, 16'h6666, 8'h55, 8'h66, 13, 0);
    idle(9);
    cur_req = "R8"; // skip followed immediately by supported cycles
    xfer(4'h0, 4'h6, 16'h7777, 8'h77, 8'h88, 13, 0);
    xfer(4'h0, 4'h0, 16'hCAFE, 8'h00, 8'hE1, 13, 0);
    xfer(4'h0, 4'hD, 16'h1111, 8'h99, 8'h12, 13, 0);
    xfer(4'h5, 4'h2, 16'hD00D, 8'h42, 8'h00, 13, 0);
    idle(2);
    cur_req = "R9"; // abandon a write mid-data, then idle
    xfer(4'h0, 4'h2, 16'h2222, 8'hAA, 8'h00, 7, 0);
    step(1'b0, 4'hF, 1'b0, 4'h0);
    idle(14);
    cur_req = "R9"; // abandon a read during data, restart at once
    xfer(4'h0, 4'h0, 16'h3333, 8'h00, 8'hBB, 10, 0);
    xfer(4'h0, 4'h0, 16'h3334, 8'h00, 8'h5D, 13, 0);
    idle(2);
    cur_req = "R10"; // frame low at the SYNC clock
    xfer(4'h0, 4'h0, 16'h9999, 8'h00, 8'h77, 8, 0);
    xfer(4'h0, 4'h2, 16'h999A, 8'h19, 8'h00, 13, 0);
    idle(2);
    cur_req = "R2"; // low frame with a non-start nibble
    step(1'b0, 4'h0, 1'b0, 4'h0);
    step(1'b0, 4'h3, 1'b0, 4'h0);
    step(1'b1, 4'h0, 1'b0, 4'h0);
    step(1'b1, 4'h1, 1'b0, 4'h0);
    idle(14);
    step(1'b0, 4'h9, 1'b0, 4'h0);
    step(1'b1, 4'h2, 1'b0, 4'h0);
    idle(14);
    xfer(4'h0, 4'h0, 16'h0042, 8'h00, 8'hF0, 13, 0);
    idle(3);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule